// File: doc/BRIEF.md
# Stochastic integrate-and-fire sampling neuron

This block is a single digital neuron that produces a binary random sample. The probability that the sample is 1 rises with the neuron's weighted input, roughly along a logistic sigmoid. Each sub-step it adds the signed integer weights of the inputs that carry a spike to a membrane potential and then subtracts a leak value taken from an external, shared source. It then compares the potential with a threshold, which is a base level plus noise from a local pseudo-random generator. When the potential reaches the threshold, the neuron fires and the potential is reloaded with a configured value.

A sampling window is opened with a `start` pulse and lasts `TW` executed sub-steps, each requested by `step`. The window's sample is the OR of all firings inside it, and it is reported with a one-cycle `done` pulse. The arithmetic uses only integer addition, subtraction, comparison and a shift-register generator. There is no multiplier, no exponent logic and no table.

Top module: `stoch_if_neuron`

## Requirements
- R1: On each executed sub-step, the new potential is the old potential plus the sum of `weights[i*W_BITS +: W_BITS]` (signed) over every i with `spikes_in[i]`=1, minus the unsigned `leak`.
- R2: The neuron fires when the new potential is greater than or equal to `thr_base` plus the low `TM` bits of the generator, zero-extended. On a firing sub-step the potential is reloaded with `reset_val`, and `spike_out` is 1 for the single cycle after that sub-step.
- R3: The generator is a 16-bit shift register loaded with `SEED` at reset. On every executed sub-step, and only then, it shifts left and takes bit15^bit13^bit12^bit10 into bit 0, so the noise changes from sub-step to sub-step.
- R4: The potential is a `V_BITS`-bit signed register that saturates at its most positive and most negative values instead of wrapping.
- R5: `start` loads `reset_val` into the potential, clears the sub-step count and the fired flag, and opens a window. When `start` and `step` are both high in the same cycle, `start` wins, no sub-step executes and the generator does not advance.
- R6: One cycle after the `TW`-th executed sub-step, `done` is 1 for exactly one cycle and `sample` shows 1 if any sub-step of the window fired, including the last one, and 0 otherwise. `sample` keeps that value until the next `done`.
- R7: A `step` while no window is open has no effect: no spike, no `done`, no change to the potential or the generator.
- R8: After reset, `spike_out`, `done` and `sample` are 0.
- R9: With `TW`=1, a window consists of one sub-step, and `done` follows it with `sample` equal to that sub-step's firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a sampling window |
| step | input | 1 | Requests one sub-step |
| spikes_in | input | N_IN | Binary input spikes for this sub-step |
| weights | input | N_IN*W_BITS | Packed signed synaptic weights |
| leak | input | LEAK_BITS | Unsigned leak subtracted each sub-step |
| thr_base | input | V_BITS | Signed base threshold |
| reset_val | input | V_BITS | Signed value loaded at start and after firing |
| spike_out | output | 1 | Firing of the previous sub-step |
| done | output | 1 | End-of-window pulse |
| sample | output | 1 | Binary sample of the last completed window |

## Verification
Two events can fall in the same cycle: a firing on the final sub-step of a window and the closing of that window. The sample must include that last firing. Vectors whose inputs keep the neuron firing on every sub-step create this case, and the bench checks `done` and `sample` against a model that ORs in the last firing. The second collision is `start` together with `step`. The bench drives it with firing inputs, expects no spike, and then runs a full window whose spike sequence shows whether the generator was left unadvanced.

// File: rtl/stoch_if_neuron.sv
module stoch_if_neuron #(
  parameter int N_IN      = 8,
  parameter int W_BITS    = 8,
  parameter int V_BITS    = 20,
  parameter int LEAK_BITS = 8,
  parameter int TM        = 8,
  parameter int TW        = 16,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     step,
  input  logic [N_IN-1:0]          spikes_in,
  input  logic [N_IN*W_BITS-1:0]   weights,
  input  logic [LEAK_BITS-1:0]     leak,
  input  logic signed [V_BITS-1:0] thr_base,
  input  logic signed [V_BITS-1:0] reset_val,
  output logic                     spike_out,
  output logic                     done,
  output logic                     sample
);
  localparam int E_BITS   = V_BITS + 2;
  localparam int CNT_BITS = $clog2(TW) + 1;
  localparam logic signed [E_BITS-1:0] VMAX = E_BITS'((64'sd1 <<< (V_BITS-1)) - 64'sd1);
  localparam logic signed [E_BITS-1:0] VMIN = -VMAX - E_BITS'(1);

  logic signed [V_BITS-1:0] pot, nxt;
  logic signed [E_BITS-1:0] wsum, raw, thr_x;
  logic [15:0]              lfsr;
  logic [CNT_BITS-1:0]      cnt;
  logic                     active, seen, fire, go;

  always_comb begin
    wsum = '0;
    for (int i = 0; i < N_IN; i++)
      if (spikes_in[i]) wsum = wsum + E_BITS'($signed(weights[i*W_BITS +: W_BITS]));
  end

  assign raw   = E_BITS'(pot) + wsum - $signed(E_BITS'(leak));
  assign nxt   = (raw > VMAX) ? V_BITS'(VMAX) : (raw < VMIN) ? V_BITS'(VMIN) : V_BITS'(raw);
  assign thr_x = E_BITS'(thr_base) + $signed(E_BITS'(lfsr[TM-1:0]));
  assign fire  = E_BITS'(nxt) >= thr_x;
  assign go    = active && step && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pot <= '0; lfsr <= SEED; cnt <= '0; active <= 1'b0; seen <= 1'b0;
      spike_out <= 1'b0; done <= 1'b0; sample <= 1'b0;
    end else begin
      spike_out <= 1'b0;
      done      <= 1'b0;
      if (start) begin
        pot <= reset_val; cnt <= '0; seen <= 1'b0; active <= 1'b1;
      end else if (go) begin
        pot       <= fire ? reset_val : nxt;
        lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        seen      <= seen | fire;
        spike_out <= fire;
        cnt       <= cnt + 1'b1;
        if (cnt == CNT_BITS'(TW-1)) begin
          active <= 1'b0;
          done   <= 1'b1;
          sample <= seen | fire;
        end
      end
    end
  end

  // R2
  spike_src_chk: assert property (@(posedge clk) disable iff (!rst_n) spike_out |-> $past(go));
  // R3
  lfsr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n) go |=> lfsr != $past(lfsr));
  // R5
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> !spike_out && !done);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  last_fire_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && !sample) |-> !spike_out);
endmodule

// File: tb/stoch_if_neuron_tb.sv
`timescale 1ns/1ps
module stoch_if_neuron_tb;
  localparam int TW = 16;
  localparam logic signed [7:0] W [8] = '{8'sd40, -8'sd8, 8'sd1, 8'sd25, -8'sd20, 8'sd12, 8'sd7, -8'sd3};
  localparam int NV = 8;
  // {spikes, leak, thr_base, reset_val}
  localparam logic [55:0] VEC [NV] = '{
    {8'hFF, 8'd0,   -20'sd130, 20'sd0},
    {8'h00, 8'd15,  20'sd50,   20'sd0},
    {8'h01, 8'd15,  20'sd50,   20'sd0},
    {8'h10, 8'd0,   -20'sd100, -20'sd50},
    {8'h6D, 8'd90,  20'sd200,  20'sd10},
    {8'hAA, 8'd3,   -20'sd5,   -20'sd5},
    {8'h29, 8'd30,  20'sd100,  20'sd0},
    {8'h0F, 8'd200, -20'sd600, 20'sd0}};
  localparam logic [55:0] SATV = {8'h6D, 8'd0, 20'sd524032, 20'sd524237};

  logic clk = 0, rst_n = 0, start = 0, step = 0, start1 = 0, step1 = 0;
  logic [7:0] spk = 0, leak = 0;
  logic [63:0] wbus;
  logic signed [19:0] thr = 0, rstv = 0;
  logic spike_out, done, sample, spike1, done1, sample1;
  int nchk = 0, nfail = 0;
  int m_pot;
  logic [15:0] m_lfsr;

  always #2 clk = ~clk;

  stoch_if_neuron #(.TW(TW)) u_dut (.clk, .rst_n, .start, .step, .spikes_in(spk), .weights(wbus),
    .leak, .thr_base(thr), .reset_val(rstv), .spike_out, .done, .sample);
  stoch_if_neuron #(.TW(1)) u_dut1 (.clk, .rst_n, .start(start1), .step(step1), .spikes_in(spk),
    .weights(wbus), .leak, .thr_base(thr), .reset_val(rstv), .spike_out(spike1), .done(done1), .sample(sample1));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step(output bit f);
    int s = 0, nx;
    for (int i = 0; i < 8; i++) if (spk[i]) s += int'(W[i]);
    nx = m_pot + s - int'(leak);
    if (nx > 524287) nx = 524287;
    if (nx < -524288) nx = -524288;
    f = nx >= int'(thr) + int'(m_lfsr[7:0]);
    m_pot = f ? int'(rstv) : nx;
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
  endtask

  task automatic apply(input logic [55:0] v);
    {spk, leak, thr, rstv} = v;
  endtask

  task automatic run_window(input logic [55:0] v, input bit collide, output bit smp);
    bit f, seen = 0;
    @(negedge clk);
    apply(v); start = 1; step = collide;
    @(negedge clk);
    if (collide) chk("R5 start wins over step", int'(spike_out), 0);
    start = 0; step = 1; m_pot = int'(rstv);
    for (int k = 0; k < TW; k++) begin
      model_step(f);
      seen |= f;
      @(negedge clk);
      chk("R1 R2 spike per sub-step", int'(spike_out), int'(f));
      chk("R6 done timing", int'(done), int'(k == TW-1));
    end
    step = 0;
    chk("R6 sample is OR of firings", int'(sample), int'(seen));
    @(negedge clk);
    chk("R6 done is one cycle", int'(done), 0);
    smp = seen;
  endtask

  initial begin
    #200000;
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    bit s;
    for (int i = 0; i < 8; i++) wbus[i*8 +: 8] = W[i];
    m_lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    chk("R8 spike_out after reset", int'(spike_out), 0);
    chk("R8 done after reset", int'(done), 0);
    chk("R8 sample after reset", int'(sample), 0);
    rst_n = 1;
    @(negedge clk);
    apply(VEC[0]); step = 1;
    @(negedge clk);
    step = 0;
    chk("R7 idle step no spike", int'(spike_out), 0);
    chk("R7 idle step no done", int'(done), 0);
    for (int n = 0; n < NV; n++) run_window(VEC[n], 1'b0, s);
    run_window(VEC[0], 1'b1, s);
    @(negedge clk);
    apply(VEC[0]); step = 1;
    @(negedge clk);
    step = 0;
    chk("R7 step after window ignored", int'(spike_out) + int'(done), 0);
    run_window(VEC[2], 1'b0, s);
    run_window(SATV, 1'b0, s);
    chk("R4 saturated potential still fires", int'(s), 1);
    @(negedge clk);
    apply({8'hFF, 8'd0, -20'sd300, 20'sd0}); start1 = 1;
    @(negedge clk);
    start1 = 0; step1 = 1;
    @(negedge clk);
    step1 = 0;
    chk("R9 Tw=1 done", int'(done1), 1);
    chk("R9 Tw=1 sample fires", int'(sample1), 1);
    apply({8'hFF, 8'd0, 20'sd1000, 20'sd0}); start1 = 1;
    @(negedge clk);
    start1 = 0; step1 = 1;
    @(negedge clk);
    step1 = 0;
    chk("R9 Tw=1 done again", int'(done1), 1);
    chk("R9 Tw=1 sample quiet", int'(sample1), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule